// File: doc/BRIEF.md
# Two-Way Mailbox Register Bank with Per-Byte Full Flags

This block lets two register-port hosts, side A and side B, pass 32-bit words to each other. Each side writes into its own four outgoing mailboxes. The other side reads the same words from its four incoming mailboxes. Every byte of every mailbox has its own full flag. A write sets the flags of the bytes it stores. A read by the receiving side clears the flags of the bytes it reads. Each side can therefore tell which bytes the other side has not yet consumed.

Both sides see one shared set of flags through a read-only status word. The flags of a side's own outgoing mailboxes sit in the low half of its status word. The flags of its incoming mailboxes sit in the high half. Either side can wipe all flags at once through a control word.

An optional external path can also fill the top byte of side B's last outgoing mailbox. It loads an 8-bit input on the rising edge of a strobe that is not tied to the block clock.

Each port accepts a word address, byte enables, a read strobe and a write strobe. Read data is combinational. It is valid in the same cycle as the read strobe, and any effect of the read takes place on the closing clock edge.

Top module: `mbx_bank_top`

## Requirements
- R1: Each side uses the same word address map. Addresses 0 to 3 are outgoing mailboxes 1 to 4, addresses 4 to 7 are incoming mailboxes 1 to 4, address 8 is the status word and address 9 is the control word. Other addresses read as zero. A word written by one side to outgoing mailbox m reads back on the other side at incoming mailbox m, and on the writer's side at outgoing mailbox m.
- R2: A write to an outgoing mailbox stores only the bytes whose byte enable is 1 (be[b] covers data bits 8b+7:8b). It sets the full flag of those bytes only.
- R3: The flag for byte b of mailbox m (m = 1..4, b = 0..3) is bit (m-1)*4+b. A side's status word holds its outgoing flags in bits 15:0 and its incoming flags in bits 31:16.
- R4: Bits 15:0 of side A's status word always equal bits 31:16 of side B's status word, and the reverse also holds.
- R5: A read of incoming mailbox m clears the flags of the bytes whose byte enable is 1, in both status views. A read of an outgoing mailbox clears no flag.
- R6: A write to the status word has no effect on any flag or mailbox data.
- R7: A write from either side to the control word, with be[0] = 1 and data bit 0 = 1, clears every full flag of both directions in one cycle. Mailbox data is kept.
- R8: While ext_en is 1, a rising edge on ext_strobe loads ext_data into bits 31:24 of side B's outgoing mailbox 4 and sets status bit 15 of that direction. This is visible within four clocks. While ext_en is 0, a strobe edge changes nothing.
- R9: If a flag is set and cleared in the same cycle (a write and a read of the same byte, or a write together with a global clear), the flag ends set.
- R10: Reset, which is synchronous and active high, clears all mailbox data and all flags to zero.
- R11: Read data reflects the registered contents in the cycle of the read. A flag cleared by a read shows as clear from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| a_addr | input | 4 | Side A word address |
| a_be | input | 4 | Side A byte enables |
| a_rd | input | 1 | Side A read strobe |
| a_wr | input | 1 | Side A write strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational |
| b_addr | input | 4 | Side B word address |
| b_be | input | 4 | Side B byte enables |
| b_rd | input | 1 | Side B read strobe |
| b_wr | input | 1 | Side B write strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational |
| ext_en | input | 1 | Enables the external byte load path |
| ext_strobe | input | 1 | External load strobe, asynchronous |
| ext_data | input | 8 | External byte to load |

## Verification
A wrong flag or data byte shows up on the very next status or mailbox read on either port. Both halves of the mirror can be read in the same cycle, so a mismatch between the two views is visible at once. A lost set, a wrong clear, or a set that loses against a clear all show as a wrong bit in the status word one cycle after the access that caused it. A fault in the external load path shows up at most four clocks after the strobe edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_NUM   = 4;
    localparam int MBX_BYTES = 4;
    localparam int MBX_DW    = MBX_BYTES * 8;
    localparam int MBX_AW    = 4;
    localparam int MBX_FW    = MBX_NUM * MBX_BYTES;

    // decoded port access
    typedef struct packed {
        logic out_sel;
        logic in_sel;
        logic stat_sel;
        logic out_wr;
        logic in_rd;
        logic ctrl_wr;
    } mbx_req_t;

    // 4-bit group of byte flags for one mailbox
    function automatic logic [MBX_BYTES-1:0] mbx_nibble(
        input logic [MBX_FW-1:0] flags,
        input int unsigned       idx
    );
        return flags[idx*MBX_BYTES +: MBX_BYTES];
    endfunction

endpackage

// File: rtl/mbx_edge_sync.sv
module mbx_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise_pulse = s2_q & ~s3_q;
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int NUM_MBX = MBX_NUM,
    parameter int ADDR_W  = MBX_AW,
    localparam int IDX_W  = $clog2(NUM_MBX)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              be0,
    input  logic              wd0,
    output mbx_req_t          req,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] IN_LO  = ADDR_W'(NUM_MBX);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(2 * NUM_MBX);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2 * NUM_MBX + 1);

    always_comb begin
        req.out_sel  = (addr < IN_LO);
        req.in_sel   = (addr >= IN_LO) && (addr < STAT_A);
        req.stat_sel = (addr == STAT_A);
        req.out_wr   = wr && req.out_sel;
        req.in_rd    = rd && req.in_sel;
        req.ctrl_wr  = wr && (addr == CTRL_A) && be0 && wd0;
    end

    // NUM_MBX is a power of two, so the low address bits select the mailbox
    assign idx = addr[IDX_W-1:0];
endmodule

// File: rtl/mbx_direction.sv
module mbx_direction
    import mbx_pkg::*;
#(
    parameter int NUM_MBX   = MBX_NUM,
    parameter int BYTES     = MBX_BYTES,
    parameter bit XL_ENABLE = 1'b0,
    localparam int IDX_W    = $clog2(NUM_MBX),
    localparam int DW       = BYTES * 8,
    localparam int FW       = NUM_MBX * BYTES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [BYTES-1:0]               wr_be,
    input  logic [DW-1:0]                  wr_data,
    input  logic                           clr_en,
    input  logic [IDX_W-1:0]               clr_idx,
    input  logic [BYTES-1:0]               clr_be,
    input  logic                           gclr,
    input  logic                           xl_pulse,
    input  logic [7:0]                     xl_data,
    output logic [NUM_MBX-1:0][DW-1:0]     data_q,
    output logic [FW-1:0]                  flags_q
);
    for (genvar m = 0; m < NUM_MBX; m++) begin : g_mbx
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            localparam bit IS_XL = XL_ENABLE && (m == NUM_MBX - 1) && (b == BYTES - 1);

            logic [7:0] byte_q;
            logic       full_q;
            logic       wr_hit, xl_hit, set_hit, clr_hit;

            assign wr_hit  = wr_en && (wr_idx == IDX_W'(m)) && wr_be[b];
            assign xl_hit  = IS_XL && xl_pulse;
            assign set_hit = wr_hit || xl_hit;
            assign clr_hit = gclr || (clr_en && (clr_idx == IDX_W'(m)) && clr_be[b]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    byte_q <= 8'h00;
                end else if (xl_hit) begin
                    byte_q <= xl_data;
                end else if (wr_hit) begin
                    byte_q <= wr_data[b*8 +: 8];
                end
            end

            // a set in the same cycle as a clear keeps the flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    full_q <= 1'b0;
                end else if (set_hit) begin
                    full_q <= 1'b1;
                end else if (clr_hit) begin
                    full_q <= 1'b0;
                end
            end

            assign data_q[m][b*8 +: 8] = byte_q;
            assign flags_q[m*BYTES + b] = full_q;
        end
    end
endmodule

// File: rtl/mbx_bank_top.sv
module mbx_bank_top
    import mbx_pkg::*;
#(
    parameter int NUM_MBX = MBX_NUM,
    parameter int BYTES   = MBX_BYTES,
    parameter int ADDR_W  = MBX_AW,
    localparam int IDX_W  = $clog2(NUM_MBX),
    localparam int DW     = BYTES * 8,
    localparam int FW     = NUM_MBX * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [BYTES-1:0]  a_be,
    input  logic              a_rd,
    input  logic              a_wr,
    input  logic [DW-1:0]     a_wdata,
    output logic [DW-1:0]     a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [BYTES-1:0]  b_be,
    input  logic              b_rd,
    input  logic              b_wr,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_rdata,
    input  logic              ext_en,
    input  logic              ext_strobe,
    input  logic [7:0]        ext_data
);
    mbx_req_t              a_req, b_req;
    logic [IDX_W-1:0]      a_idx, b_idx;
    logic [NUM_MBX-1:0][DW-1:0] ab_data, ba_data;
    logic [FW-1:0]         flags_ab, flags_ba;
    logic                  strobe_rise, xl_pulse, gclr;

    mbx_port_decode #(.NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W)) u_dec_a (
        .addr(a_addr), .rd(a_rd), .wr(a_wr), .be0(a_be[0]), .wd0(a_wdata[0]),
        .req(a_req), .idx(a_idx)
    );

    mbx_port_decode #(.NUM_MBX(NUM_MBX), .ADDR_W(ADDR_W)) u_dec_b (
        .addr(b_addr), .rd(b_rd), .wr(b_wr), .be0(b_be[0]), .wd0(b_wdata[0]),
        .req(b_req), .idx(b_idx)
    );

    mbx_edge_sync u_xsync (
        .clk(clk), .rst(rst), .async_in(ext_strobe), .rise_pulse(strobe_rise)
    );

    assign xl_pulse = strobe_rise && ext_en;
    assign gclr     = a_req.ctrl_wr || b_req.ctrl_wr;

    // A outgoing / B incoming
    mbx_direction #(.NUM_MBX(NUM_MBX), .BYTES(BYTES), .XL_ENABLE(1'b0)) u_dir_ab (
        .clk(clk), .rst(rst),
        .wr_en(a_req.out_wr), .wr_idx(a_idx), .wr_be(a_be), .wr_data(a_wdata),
        .clr_en(b_req.in_rd), .clr_idx(b_idx), .clr_be(b_be),
        .gclr(gclr), .xl_pulse(1'b0), .xl_data(8'h00),
        .data_q(ab_data), .flags_q(flags_ab)
    );

    // B outgoing / A incoming, with the external byte path
    mbx_direction #(.NUM_MBX(NUM_MBX), .BYTES(BYTES), .XL_ENABLE(1'b1)) u_dir_ba (
        .clk(clk), .rst(rst),
        .wr_en(b_req.out_wr), .wr_idx(b_idx), .wr_be(b_be), .wr_data(b_wdata),
        .clr_en(a_req.in_rd), .clr_idx(a_idx), .clr_be(a_be),
        .gclr(gclr), .xl_pulse(xl_pulse), .xl_data(ext_data),
        .data_q(ba_data), .flags_q(flags_ba)
    );

    always_comb begin
        a_rdata = '0;
        if (a_req.out_sel) begin
            a_rdata = ab_data[a_idx];
        end else if (a_req.in_sel) begin
            a_rdata = ba_data[a_idx];
        end else if (a_req.stat_sel) begin
            a_rdata[FW-1:0]    = flags_ab;
            a_rdata[2*FW-1:FW] = flags_ba;
        end
    end

    always_comb begin
        b_rdata = '0;
        if (b_req.out_sel) begin
            b_rdata = ba_data[b_idx];
        end else if (b_req.in_sel) begin
            b_rdata = ab_data[b_idx];
        end else if (b_req.stat_sel) begin
            b_rdata[FW-1:0]    = flags_ba;
            b_rdata[2*FW-1:FW] = flags_ab;
        end
    end
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MBX_AW-1:0] a_addr,
    input logic [3:0]        a_be,
    input logic              a_rd,
    input logic              a_wr,
    input logic [MBX_DW-1:0] a_wdata,
    input logic [MBX_DW-1:0] a_rdata,
    input logic [MBX_AW-1:0] b_addr,
    input logic [3:0]        b_be,
    input logic              b_rd,
    input logic              b_wr,
    input logic [MBX_DW-1:0] b_rdata,
    input logic              ext_en,
    input logic [MBX_FW-1:0] flags_ab,
    input logic [MBX_FW-1:0] flags_ba
);
    logic a_out, b_out, a_in, b_in;
    assign a_out = a_addr < 4'd4;
    assign b_out = b_addr < 4'd4;
    assign a_in  = (a_addr >= 4'd4) && (a_addr < 4'd8);
    assign b_in  = (b_addr >= 4'd4) && (b_addr < 4'd8);

    // R2 and R9: enabled bytes end set even if the other side reads them
    p_write_sets_a_r2: assert property (@(posedge clk) disable iff (rst)
        (a_wr && a_out) |=>
        ((mbx_nibble(flags_ab, 32'($past(a_addr[1:0]))) & $past(a_be)) == $past(a_be)));

    p_write_sets_b_r2: assert property (@(posedge clk) disable iff (rst)
        (b_wr && b_out) |=>
        ((mbx_nibble(flags_ba, 32'($past(b_addr[1:0]))) & $past(b_be)) == $past(b_be)));

    p_read_clears_b_r5: assert property (@(posedge clk) disable iff (rst)
        (b_rd && b_in && !a_wr) |=>
        ((mbx_nibble(flags_ab, 32'($past(b_addr[1:0]))) & $past(b_be)) == 4'h0));

    p_read_clears_a_r5: assert property (@(posedge clk) disable iff (rst)
        (a_rd && a_in && !b_wr && !ext_en) |=>
        ((mbx_nibble(flags_ba, 32'($past(a_addr[1:0]))) & $past(a_be)) == 4'h0));

    p_mirror_r4: assert property (@(posedge clk) disable iff (rst)
        (a_addr == 4'd8 && b_addr == 4'd8) |->
        (a_rdata[15:0] == b_rdata[31:16] && a_rdata[31:16] == b_rdata[15:0]));

    p_status_ro_r6: assert property (@(posedge clk) disable iff (rst)
        (a_wr && a_addr == 4'd8 && !a_rd && !b_wr && !b_rd && !ext_en) |=>
        ($stable(flags_ab) && $stable(flags_ba)));

    p_global_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (a_wr && a_addr == 4'd9 && a_be[0] && a_wdata[0] && !b_wr && !ext_en) |=>
        (flags_ab == '0 && flags_ba == '0));

    p_ext_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!ext_en && !b_wr) |=> !$rose(flags_ba[15]));
endmodule

bind mbx_bank_top mbx_bank_chk u_chk (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_be(a_be), .a_rd(a_rd), .a_wr(a_wr),
    .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_be(b_be), .b_rd(b_rd), .b_wr(b_wr),
    .b_rdata(b_rdata), .ext_en(ext_en),
    .flags_ab(flags_ab), .flags_ba(flags_ba)
);

// File: tb/mbx_bank_top_tb.sv
module mbx_bank_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  a_addr = '0, b_addr = '0;
    logic [3:0]  a_be = '0, b_be = '0;
    logic        a_rd = 1'b0, a_wr = 1'b0, b_rd = 1'b0, b_wr = 1'b0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        ext_en = 1'b0, ext_strobe = 1'b0;
    logic [7:0]  ext_data = '0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          side;
        logic [31:0] data;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] m_ab [4];
    logic [31:0] m_ba [4];
    logic [15:0] f_ab, f_ba;

    always #4 clk = ~clk;

    mbx_bank_top u_dut (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_be(a_be), .a_rd(a_rd), .a_wr(a_wr),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_be(b_be), .b_rd(b_rd), .b_wr(b_wr),
        .b_wdata(b_wdata), .b_rdata(b_rdata),
        .ext_en(ext_en), .ext_strobe(ext_strobe), .ext_data(ext_data)
    );

    function automatic logic [31:0] model_read(input bit side, input logic [3:0] ad);
        if (ad < 4) return side ? m_ba[ad[1:0]] : m_ab[ad[1:0]];
        if (ad < 8) return side ? m_ab[ad[1:0]] : m_ba[ad[1:0]];
        if (ad == 8) return side ? {f_ab, f_ba} : {f_ba, f_ab};
        return 32'h0;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // driver: one cycle of activity on both ports, model updated per requirements
    task automatic cyc(input logic ard, input logic awr, input logic [3:0] aad,
                       input logic [3:0] abe, input logic [31:0] awd,
                       input logic brd, input logic bwr, input logic [3:0] bad,
                       input logic [3:0] bbe, input logic [31:0] bwd,
                       input string req);
        bit gc;
        @(negedge clk);
        a_rd = ard; a_wr = awr; a_addr = aad; a_be = abe; a_wdata = awd;
        b_rd = brd; b_wr = bwr; b_addr = bad; b_be = bbe; b_wdata = bwd;
        if (ard) exp_q.push_back('{1'b0, model_read(1'b0, aad), req});
        if (brd) exp_q.push_back('{1'b1, model_read(1'b1, bad), req});
        gc = (awr && aad == 4'd9 && abe[0] && awd[0]) || (bwr && bad == 4'd9 && bbe[0] && bwd[0]);
        if (gc) begin f_ab = '0; f_ba = '0; end
        if (ard && aad >= 4 && aad < 8) f_ba &= ~({12'h0, abe} << (aad[1:0] * 4));
        if (brd && bad >= 4 && bad < 8) f_ab &= ~({12'h0, bbe} << (bad[1:0] * 4));
        if (awr && aad < 4) begin
            for (int b = 0; b < 4; b++) if (abe[b]) m_ab[aad[1:0]][b*8 +: 8] = awd[b*8 +: 8];
            f_ab |= {12'h0, abe} << (aad[1:0] * 4);
        end
        if (bwr && bad < 4) begin
            for (int b = 0; b < 4; b++) if (bbe[b]) m_ba[bad[1:0]][b*8 +: 8] = bwd[b*8 +: 8];
            f_ba |= {12'h0, bbe} << (bad[1:0] * 4);
        end
        @(posedge clk);
        #1;
        a_rd = 0; a_wr = 0; b_rd = 0; b_wr = 0;
    endtask

    task automatic a_wr_t(input logic [3:0] ad, input logic [3:0] be, input logic [31:0] d, input string r);
        cyc(0, 1, ad, be, d, 0, 0, 0, 0, 0, r);
    endtask
    task automatic b_wr_t(input logic [3:0] ad, input logic [3:0] be, input logic [31:0] d, input string r);
        cyc(0, 0, 0, 0, 0, 0, 1, ad, be, d, r);
    endtask
    task automatic a_rd_t(input logic [3:0] ad, input logic [3:0] be, input string r);
        cyc(1, 0, ad, be, 0, 0, 0, 0, 0, 0, r);
    endtask
    task automatic b_rd_t(input logic [3:0] ad, input logic [3:0] be, input string r);
        cyc(0, 0, 0, 0, 0, 1, 0, ad, be, 0, r);
    endtask
    task automatic both_stat(input string r);
        cyc(1, 0, 4'd8, 4'hF, 0, 1, 0, 4'd8, 4'hF, 0, r);
    endtask

    task automatic ext_pulse(input logic en, input logic [7:0] d);
        @(negedge clk);
        ext_en = en; ext_data = d; ext_strobe = 1'b1;
        repeat (2) @(negedge clk);
        ext_strobe = 1'b0;
        repeat (4) @(negedge clk);
        if (en) begin
            m_ba[3][31:24] = d;
            f_ba[15] = 1'b1;
        end
        ext_en = 1'b0;
    endtask

    // monitor: compare read data against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (a_rd) compare(1'b0, a_rdata);
            if (b_rd) compare(1'b1, b_rdata);
        end
    end

    task automatic compare(input bit side, input logic [31:0] act);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s side: unexpected read, actual %h expected none", side ? "B" : "A", act);
            return;
        end
        e = exp_q.pop_front();
        if (e.side != side || act !== e.data) begin
            errors++;
            $display("FAIL %s side %s: actual %h expected %h", e.req, side ? "B" : "A", act, e.data);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_ab[i] = '0; m_ba[i] = '0; end
        f_ab = '0; f_ba = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10 reset state
        both_stat("R10 status after reset");
        a_rd_t(4'd4, 4'hF, "R10 incoming data after reset");

        // R2 R3: partial write to outgoing mailbox 2, bytes 0 and 1 -> bits 4,5
        a_wr_t(4'd1, 4'b0011, 32'hAABBCCDD, "R2");
        a_rd_t(4'd8, 4'hF, "R3 flag position");
        both_stat("R4 mirrored views");
        b_rd_t(4'd5, 4'b0001, "R2 only enabled bytes stored");
        // R11: cleared flag visible next cycle
        a_rd_t(4'd8, 4'hF, "R11 clear visible next cycle");
        b_rd_t(4'd8, 4'hF, "R5 clear in both views");

        // R1: B to A pairing, outgoing read does not clear
        b_wr_t(4'd0, 4'hF, 32'h12345678, "R1");
        b_rd_t(4'd0, 4'hF, "R1 own outgoing readback");
        a_rd_t(4'd8, 4'hF, "R5 outgoing read keeps flags");
        a_rd_t(4'd4, 4'b1100, "R1 incoming pairing");
        a_rd_t(4'd8, 4'hF, "R5 partial clear");

        // R6: status write ignored
        a_wr_t(4'd8, 4'hF, 32'hFFFFFFFF, "R6");
        both_stat("R6 status write ignored");

        // R7: global clear from B, data kept
        a_wr_t(4'd2, 4'hF, 32'hCAFEF00D, "R7");
        b_wr_t(4'd9, 4'h1, 32'h1, "R7");
        both_stat("R7 all flags cleared");
        b_rd_t(4'd6, 4'hF, "R7 data kept after clear");

        // R9: write and read of same byte in one cycle, set wins
        cyc(0, 1, 4'd2, 4'hF, 32'h0BADBEEF, 1, 0, 4'd6, 4'hF, 0, "R9 old data on read");
        both_stat("R9 set wins over clear");
        // R9: write together with global clear
        cyc(0, 1, 4'd3, 4'b1000, 32'h55000000, 0, 1, 4'd9, 4'h1, 32'h1, "R9");
        both_stat("R9 set wins over global clear");

        // R8: external load
        ext_pulse(1'b1, 8'h5A);
        b_rd_t(4'd8, 4'hF, "R8 ext load sets bit 15");
        a_rd_t(4'd7, 4'b1000, "R8 ext byte data");
        a_rd_t(4'd8, 4'hF, "R8 ext flag cleared by read");
        ext_pulse(1'b0, 8'h77);
        a_rd_t(4'd7, 4'hF, "R8 disabled strobe keeps data");
        b_rd_t(4'd8, 4'hF, "R8 disabled strobe keeps flag");

        // mixed traffic on both sides
        for (int i = 0; i < 60; i++) begin
            logic [3:0] aa, ba;
            logic       aw, bw;
            aa = 4'($urandom_range(0, 9));
            ba = 4'($urandom_range(0, 9));
            aw = 1'($urandom_range(0, 1));
            bw = 1'($urandom_range(0, 1));
            cyc(!aw, aw, aa, 4'($urandom_range(1, 15)), $urandom,
                !bw, bw, ba, 4'($urandom_range(1, 15)), $urandom, "R1 R2 R5 mixed");
            if (i % 5 == 4) both_stat("R4 mixed status");
        end

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: actual %0d pending reads expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule